// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block sits in front of a synchronous static RAM with a 36-bit word, held as four 9-bit byte lanes. Each lane carries eight data bits and one parity bit. On every rising clock edge it registers an address, a chip select, two address strobes, a burst advance input and a set of write controls. From these it classifies the cycle as one of four kinds: deselect, burst start, burst continue or burst hold. It also decides whether the cycle reads or writes.

The two strobes do not behave alike. The processor strobe only counts while chip select is low. It always starts a read, and it takes priority over the controller strobe. The controller strobe starts a read or a write depending on the write controls. When chip select is high, the controller strobe deselects the device instead.

Between strobes, the burst advance input steps through a four-word group in linear or interleaved order, or holds the current word. Read data leaves through a registered output stage. An asynchronous output enable gates the output.

Top module: `pbsram_ctrl`

## Requirements
- R1: With `strb_p_n` low and `cs_n` low at an edge, `addr_i` is loaded and the cycle is a read, whatever `strb_c_n`, `lane_n`, `bwe_n` and `gw_n` are.
- R2: With `strb_c_n` low, `cs_n` low and `strb_p_n` high at an edge, `addr_i` is loaded. The cycle is a write if the write condition of R5 holds, and a read otherwise.
- R3: While `cs_n` is high, `strb_p_n` has no effect. The cycle then follows R4 or R8.
- R4: `strb_c_n` low with `cs_n` high deselects the device. The output is no longer driven after the following edge. Later cycles with no strobe active perform no access until a new start.
- R5: A cycle writes when `gw_n` is low, or when `bwe_n` is low and at least one bit of `lane_n` is low. `gw_n` low writes all four lanes regardless of `bwe_n` and `lane_n`. `bwe_n` high with `gw_n` high makes the cycle a read.
- R6: Lane i is written when `lane_n[i]` is low and `bwe_n` is low. Lane i occupies `wdata`/`rdata` bits [9i+8:9i], and bit 9i+8 is its parity bit. Lanes not enabled keep their contents.
- R7: After a processor-strobe start, the next edge writes to the loaded address if the write controls are asserted and `adv_n` is high at that edge.
- R8: With both strobes inactive and a burst open, `adv_n` low moves to the next burst address and `adv_n` high repeats the current address. Either case applies to both reads and writes.
- R9: Burst addresses change only the two low address bits. A count k runs 0,1,2,3 and then wraps to 0. With `lin_mode`=1 the low bits are (start+k) mod 4. With `lin_mode`=0 they are start XOR k.
- R10: Data read for an access registered at edge N appears on `rdata` after edge N+1. `rdata_drv` is high exactly when that data is valid and `oe_n` is low, and `oe_n` acts without waiting for a clock.
- R11: After a write cycle, or a cycle with no access, the output is not driven after the following edge until a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | AW | External word address |
| cs_n | input | 1 | Chip select, active low |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| bwe_n | input | 1 | Lane write qualifier, active low |
| gw_n | input | 1 | Global write, active low |
| lin_mode | input | 1 | 1 selects linear burst order, 0 interleaved |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data, zero when not driven |
| rdata_drv | output | 1 | High when `rdata` is being driven |

## Verification
The hardest case to reach is the cycle just after a processor-strobe start. The write controls then apply to the freshly loaded word only if advance is high. A nearby case is a held burst whose processor strobe is low while chip select is high, so the strobe must be ignored. Directed sequences build both cases on purpose. A random phase then mixes strobes, chip select, advance and write controls with their own weights, so starts, holds, advances, deselects and partial-lane writes interleave. A reference model in the bench predicts every output cycle, and that model includes a read of a word being rewritten on the same edge.

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr_i,
  input  logic                  cs_n,
  input  logic                  strb_p_n,
  input  logic                  strb_c_n,
  input  logic                  adv_n,
  input  logic [LANES-1:0]      lane_n,
  input  logic                  bwe_n,
  input  logic                  gw_n,
  input  logic                  lin_mode,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic                  oe_n,
  output logic [LANES*LW-1:0]   rdata,
  output logic                  rdata_drv
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic          active, rd1, out_vld;
  logic [AW-1:0] base, cur_addr, eff_addr;
  logic [1:0]    cnt, next_cnt, lo;
  logic [DW-1:0] mem_rd, rdq;
  logic [LANES-1:0] lane_wr;

  wire start_p = !strb_p_n && !cs_n;
  wire start_c = !strb_c_n && !cs_n && strb_p_n;
  wire desel   = !strb_c_n && cs_n;
  wire start   = start_p || start_c;
  wire cont    = !start && !desel && active;
  wire step    = cont && !adv_n;

  always_comb
    for (int i = 0; i < LANES; i++)
      lane_wr[i] = !gw_n || (!bwe_n && !lane_n[i]);

  wire wr_req = |lane_wr;
  wire do_wr  = (start_c || cont) && wr_req;
  wire do_rd  = start_p || ((start_c || cont) && !wr_req);

  assign next_cnt = step ? cnt + 2'd1 : cnt;
  assign lo       = lin_mode ? base[1:0] + next_cnt : base[1:0] ^ next_cnt;
  assign eff_addr = start ? addr_i : {base[AW-1:2], lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      base     <= '0;
      cnt      <= '0;
      cur_addr <= '0;
      rd1      <= 1'b0;
      out_vld  <= 1'b0;
    end else begin
      if (start) begin
        active <= 1'b1;
        base   <= addr_i;
        cnt    <= '0;
      end else begin
        if (desel) active <= 1'b0;
        cnt <= next_cnt;
      end
      if (start || cont) cur_addr <= eff_addr;
      rd1     <= do_rd;
      out_vld <= rd1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] mem [DEPTH];
      always_ff @(posedge clk)
        if (do_wr && lane_wr[g]) mem[eff_addr] <= wdata[g*LW +: LW];
      assign mem_rd[g*LW +: LW] = mem[cur_addr];
    end
  endgenerate

  always_ff @(posedge clk)
    if (rd1) rdq <= mem_rd;

  assign rdata_drv = out_vld && !oe_n;
  assign rdata     = rdata_drv ? rdq : '0;

  p_pread_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_p_n && !cs_n) |=> ##1 out_vld);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_c_n && !cs_n) |=> (cur_addr == $past(addr_i)));
  p_pignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !strb_p_n && strb_c_n && adv_n) |=> $stable(cur_addr));
  p_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_c_n && cs_n) |=> ##1 !out_vld);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_p_n && strb_c_n && adv_n) |=> $stable(cur_addr));
  p_wr_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> ##1 !out_vld);
endmodule

// File: tb/sim_pbsram_ctrl.sv
`timescale 1ns/1ps
module sim_pbsram_ctrl;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr_i = '0;
  logic cs_n = 1, strb_p_n = 1, strb_c_n = 1, adv_n = 1, bwe_n = 1, gw_n = 1;
  logic lin_mode = 1, oe_n = 0;
  logic [3:0] lane_n = 4'hF;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdata_drv;

  int checks = 0, errors = 0;

  pbsram_ctrl #(.AW(AW)) u0 (.clk, .rst_n, .addr_i, .cs_n, .strb_p_n, .strb_c_n,
    .adv_n, .lane_n, .bwe_n, .gw_n, .lin_mode, .wdata, .oe_n, .rdata, .rdata_drv);

  always #2.5 clk = ~clk;

  logic [DW-1:0] m_mem [1<<AW];
  logic m_act = 0, m_rd1 = 0, m_ovld = 0;
  logic [AW-1:0] m_base = '0, m_raddr = '0;
  logic [1:0] m_cnt = '0;
  logic [DW-1:0] m_dq = '0;

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag);
    logic ed;
    ed = m_ovld && !oe_n;
    chk({35'd0, rdata_drv}, {35'd0, ed}, {tag, " drive"});
    if (ed) chk(rdata, m_dq, {tag, " data"});
  endtask

  task automatic cyc(input logic p, input logic c, input logic cs, input logic adv,
                     input logic [3:0] ln, input logic bwe, input logic gw,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe,
                     input string tag);
    logic sp, sc, ds, ct, wr, wen, rd;
    logic [3:0] lw;
    logic [AW-1:0] ea;
    look(tag);
    strb_p_n = p; strb_c_n = c; cs_n = cs; adv_n = adv; lane_n = ln;
    bwe_n = bwe; gw_n = gw; addr_i = a; wdata = d; oe_n = oe;
    m_ovld = m_rd1;
    if (m_rd1) m_dq = m_mem[m_raddr];
    sp = !p && !cs;
    sc = !c && !cs && !sp;
    ds = !c && cs;
    ct = !sp && !sc && !ds && m_act;
    for (int i = 0; i < 4; i++) lw[i] = !gw || (!bwe && !ln[i]);
    wr = |lw;
    ea = '0;
    if (sp || sc) begin
      m_base = a; m_cnt = 0; m_act = 1; ea = a;
    end else if (ct) begin
      if (!adv) m_cnt = m_cnt + 2'd1;
      ea = {m_base[AW-1:2], lin_mode ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt};
    end
    if (ds) m_act = 0;
    wen = (sc || ct) && wr;
    rd  = sp || ((sc || ct) && !wr);
    if (wen)
      for (int i = 0; i < 4; i++)
        if (lw[i]) m_mem[ea][9*i +: 9] = d[9*i +: 9];
    m_rd1 = rd;
    if (sp || sc || ct) m_raddr = ea;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1,1,0,1,4'hF,1,1,'0,'0,0,tag);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk({35'd0, rdata_drv}, 36'd0, "R10 reset");
    rst_n = 1;
    @(negedge clk);
    // R5 global write preload of every word
    for (int i = 0; i < (1<<AW); i++)
      cyc(1,0,0,1,4'hF,1,0,AW'(i),{$urandom(),4'(i)},0,"R5");
    // R1 processor start ignores controller strobe and lane enables
    cyc(0,0,0,1,4'h0,0,1,6'd5,'1,0,"R1");
    idle(3,"R1");
    // R6 single lane write, then R2 controller read
    cyc(1,0,0,1,4'b1101,0,1,6'd9,36'hABCDE1234,0,"R6");
    cyc(1,0,0,1,4'hF,1,1,6'd9,'0,0,"R2");
    idle(2,"R6");
    // R5 lane enables with qualifier high is a read
    cyc(1,0,0,1,4'h0,1,1,6'd9,'1,0,"R5");
    idle(2,"R5");
    // R7 processor start then write on next edge with advance high
    cyc(0,1,0,1,4'hF,1,1,6'd12,'0,0,"R7");
    cyc(1,1,0,1,4'hF,1,0,6'd0,36'h123456789,0,"R7");
    cyc(1,0,0,1,4'hF,1,1,6'd12,'0,0,"R7");
    idle(2,"R11");
    // R9 linear burst with wrap
    lin_mode = 1;
    cyc(0,1,0,1,4'hF,1,1,6'd6,'0,0,"R9");
    for (int i = 0; i < 5; i++) cyc(1,1,0,0,4'hF,1,1,'0,'0,0,"R9");
    // R3 processor strobe with chip select high is ignored, burst holds
    cyc(0,1,1,1,4'hF,1,1,6'd33,'0,0,"R3");
    cyc(0,1,1,0,4'hF,1,1,6'd33,'0,0,"R3");
    // R10 asynchronous output enable
    look("R10");
    oe_n = 1; #1 chk({35'd0, rdata_drv}, 36'd0, "R10 oe high");
    oe_n = 0; #1 chk({35'd0, rdata_drv}, 36'd1, "R10 oe low");
    // R9 interleaved burst with wrap
    lin_mode = 0;
    cyc(0,1,0,1,4'hF,1,1,6'd7,'0,0,"R9");
    for (int i = 0; i < 5; i++) cyc(1,1,0,0,4'hF,1,1,'0,'0,0,"R9");
    // R8 hold, then burst write continue, then read back
    cyc(1,1,0,1,4'hF,1,1,'0,'0,0,"R8");
    cyc(1,1,0,1,4'hF,1,1,'0,'0,0,"R8");
    cyc(1,0,0,1,4'hF,1,0,6'd20,36'h111111111,0,"R8");
    cyc(1,1,0,0,4'h0,0,1,'0,36'h222222222,0,"R8");
    cyc(1,1,0,1,4'b0110,0,1,'0,36'h333333333,0,"R8");
    cyc(0,1,0,1,4'hF,1,1,6'd20,'0,0,"R8");
    for (int i = 0; i < 4; i++) cyc(1,1,0,0,4'hF,1,1,'0,'0,0,"R8");
    // R4 deselect, idle cycles do no access
    cyc(1,0,1,1,4'hF,1,1,'0,'0,0,"R4");
    idle(3,"R4");
    cyc(1,1,0,1,4'hF,1,0,'0,'1,0,"R4");
    idle(2,"R4");
    // R11 write then no output
    cyc(0,1,0,1,4'hF,1,1,6'd40,'0,0,"R11");
    cyc(1,1,0,1,4'hF,1,0,'0,36'h0F0F0F0F0,0,"R11");
    idle(3,"R11");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic p, c, cs, adv, bwe, gw, oe;
      logic [3:0] ln;
      p   = ($urandom % 5) != 0;
      c   = ($urandom % 4) != 0;
      cs  = ($urandom % 7) == 0;
      adv = ($urandom % 2) != 0;
      bwe = ($urandom % 2) != 0;
      gw  = ($urandom % 5) != 0;
      oe  = ($urandom % 6) == 0;
      ln  = 4'($urandom);
      if (!cs && (!p || !c)) lin_mode = 1'($urandom);
      cyc(p,c,cs,adv,ln,bwe,gw,AW'($urandom),{$urandom(),4'($urandom)},oe,"R8 R9 random");
    end
    idle(3,"R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule